// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two cross-port interrupt signals of a dual-port memory. The two highest addresses of the shared array act as mailboxes, one for each direction. When one port writes its outgoing mailbox, the interrupt of the opposite port is raised. That interrupt stays raised until the receiving port reads the same mailbox. The block has no data path of its own, because the mailbox bytes are kept in the shared array.

Each port supplies an active-low chip select, a read/write strobe (low means write), an active-low output enable and an address. All of these are sampled on the rising clock edge. A flag changes on the edge that samples the access, so the interrupt output moves one cycle after the access is presented. Reset is synchronous and active low.

Top module: `mbx_irq_flags`

## Requirements
- R1: While reset is low at a clock edge, both interrupt outputs are high after that edge.
- R2: A left-port write (cs low, rw low) to the top address (all ones, 0x7FF for 11 address bits) drives the right interrupt low on the next cycle.
- R3: A right-port read (cs low, rw high, oe low) of the top address returns the right interrupt high on the next cycle.
- R4: A right-port write (cs low, rw low) to the top address minus one (0x7FE for 11 bits) drives the left interrupt low on the next cycle.
- R5: A left-port read (cs low, rw high, oe low) of the top address minus one returns the left interrupt high on the next cycle.
- R6: An access with cs high does not change either flag. A read with oe high does not clear a flag.
- R7: A port that writes its own incoming mailbox, or reads its outgoing mailbox, does not change either flag.
- R8: When a set and a clear of the same flag are sampled on the same edge, the flag ends up set.
- R9: Accesses to any address other than the two mailboxes do not change either flag, and both flags hold their value while no qualifying access is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs_n | input | 1 | Left chip select, active low |
| l_rw_n | input | 1 | Left read/write, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| r_cs_n | input | 1 | Right chip select, active low |
| r_rw_n | input | 1 | Right read/write, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| irq_l_n | output | 1 | Interrupt to left port, active low |
| irq_r_n | output | 1 | Interrupt to right port, active low |

## Verification
The bench builds the block with ADDR_W = 4, which places the mailboxes at 0xF and 0xE. At that width every address can be tried on each port with all eight combinations of cs, rw and oe. Each sweep starts once from both flags clear and once from both flags set, so both set and clear effects are visible for every case. Further directed steps present simultaneous accesses from the two ports to check set priority and the independence of the two flags.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned MBX_CALC_W = 32;

  // mailbox index 0 is the top address, index 1 the one below it
  function automatic logic [MBX_CALC_W-1:0] box_addr(input int unsigned aw, input int unsigned idx);
    logic [MBX_CALC_W-1:0] top;
    top = (MBX_CALC_W'(1) << aw) - MBX_CALC_W'(1);
    return top - MBX_CALC_W'(idx);
  endfunction

  function automatic logic is_wr(input logic cs_n, input logic rw_n);
    return !cs_n && !rw_n;
  endfunction

  function automatic logic is_rd(input logic cs_n, input logic rw_n, input logic oe_n);
    return !cs_n && rw_n && !oe_n;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned OUT_IDX = 0
) (
  input  logic              cs_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              post_evt,
  output logic              take_evt
);
  localparam int unsigned IN_IDX = 1 - OUT_IDX;
  localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(mbx_pkg::box_addr(ADDR_W, OUT_IDX));
  localparam logic [ADDR_W-1:0] IN_A  = ADDR_W'(mbx_pkg::box_addr(ADDR_W, IN_IDX));

  logic wr_q, rd_q;

  always_comb begin
    wr_q     = mbx_pkg::is_wr(cs_n, rw_n);
    rd_q     = mbx_pkg::is_rd(cs_n, rw_n, oe_n);
    post_evt = wr_q && (addr == OUT_A);
    take_evt = rd_q && (addr == IN_A);
  end

  always_comb begin
    AST_EVT_EXCL: assert (!(post_evt && take_evt)); // R7
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  AST_FLAG_RST:  assert property (@(posedge clk) !rst_n |=> !flag); // R1
  AST_SET_WINS:  assert property (@(posedge clk) disable iff (!rst_n) set_evt |=> flag); // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (clr_evt && !set_evt) |=> !flag); // R3
  AST_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (!set_evt && !clr_evt) |=> $stable(flag)); // R9
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              irq_l_n,
  output logic              irq_r_n
);
  localparam int unsigned NPORT = 2;
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(mbx_pkg::box_addr(ADDR_W, 0));
  localparam logic [ADDR_W-1:0] NXT_A = ADDR_W'(mbx_pkg::box_addr(ADDR_W, 1));

  logic [NPORT-1:0] cs_n_v, rw_n_v, oe_n_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic [NPORT-1:0] post_evt, take_evt, flag;

  assign cs_n_v    = {r_cs_n, l_cs_n};
  assign rw_n_v    = {r_rw_n, l_rw_n};
  assign oe_n_v    = {r_oe_n, l_oe_n};
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  // port k posts into mailbox k; flag k belongs to port k and is fed by mailbox 1-k
  for (genvar k = 0; k < NPORT; k++) begin : g_port
    mbx_port_decode #(.ADDR_W(ADDR_W), .OUT_IDX(k)) u_dec (
      .cs_n     (cs_n_v[k]),
      .rw_n     (rw_n_v[k]),
      .oe_n     (oe_n_v[k]),
      .addr     (addr_v[k]),
      .post_evt (post_evt[k]),
      .take_evt (take_evt[k])
    );
    mbx_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (post_evt[NPORT-1-k]),
      .clr_evt (take_evt[k]),
      .flag    (flag[k])
    );
  end

  assign irq_l_n = ~flag[0];
  assign irq_r_n = ~flag[1];

  AST_RST_HIGH: assert property (@(posedge clk) !rst_n |=> (irq_l_n && irq_r_n)); // R1
  AST_R_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_r_n) |-> $past(!l_cs_n && !l_rw_n && l_addr == TOP_A)); // R2
  AST_R_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_r_n) && $past(rst_n)) |-> $past(!r_cs_n && r_rw_n && !r_oe_n && r_addr == TOP_A)); // R3
  AST_L_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_l_n) |-> $past(!r_cs_n && !r_rw_n && r_addr == NXT_A)); // R4
  AST_L_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_l_n) && $past(rst_n)) |-> $past(!l_cs_n && l_rw_n && !l_oe_n && l_addr == NXT_A)); // R5
endmodule

// File: tb/sim_mbx_irq_flags.sv
`timescale 1ns/1ps
module sim_mbx_irq_flags;
  localparam int AW  = 4;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
  logic r_cs_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic irq_l_n, irq_r_n;
  int n_chk = 0, n_bad = 0;
  logic ef_l, ef_r;

  always #4 clk = ~clk;

  mbx_irq_flags #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
  );

  task automatic check(input string req, input logic exp_l, input logic exp_r);
    n_chk++;
    if (irq_l_n !== exp_l || irq_r_n !== exp_r) begin
      n_bad++;
      $display("FAIL %s: irq_l_n/irq_r_n actual %b%b expected %b%b", req, irq_l_n, irq_r_n, exp_l, exp_r);
    end
  endtask

  task automatic idle();
    l_cs_n = 1; l_rw_n = 1; l_oe_n = 1; l_addr = '0;
    r_cs_n = 1; r_rw_n = 1; r_oe_n = 1; r_addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    ef_l = 0; ef_r = 0;
  endtask

  // one access per port for one cycle; then sample after the registering edge
  task automatic step(input logic [2:0] lc, input int la, input logic [2:0] rc, input int ra);
    @(negedge clk);
    {l_cs_n, l_rw_n, l_oe_n} = lc; l_addr = AW'(la);
    {r_cs_n, r_rw_n, r_oe_n} = rc; r_addr = AW'(ra);
    @(negedge clk);
    idle();
  endtask

  localparam logic [2:0] WR = 3'b001, RD = 3'b010, NOP = 3'b111;

  function automatic string tag_of(input int p, input logic [2:0] c, input int a);
    logic wr, rd;
    wr = !c[2] && !c[1];
    rd = !c[2] && c[1] && !c[0];
    if (!wr && !rd) return "R6";
    if (wr && a == TOP - p) return (p == 0) ? "R2" : "R4";
    if (rd && a == TOP - (1 - p)) return (p == 1) ? "R3" : "R5";
    if (a >= TOP - 1) return "R7";
    return "R9";
  endfunction

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", 1'b1, 1'b1);

    for (int init = 0; init < 2; init++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a <= TOP; a++)
          for (int c = 0; c < 8; c++) begin
            logic wr, rd;
            do_reset();
            if (init == 1) begin
              step(WR, TOP, WR, TOP - 1);
              ef_l = 1; ef_r = 1;
            end
            if (p == 0) step(3'(c), a, NOP, 0);
            else        step(NOP, 0, 3'(c), a);
            wr = (c[2] == 0) && (c[1] == 0);
            rd = (c[2] == 0) && (c[1] == 1) && (c[0] == 0);
            if (p == 0) begin
              if (wr && a == TOP)     ef_r = 1;
              if (rd && a == TOP - 1) ef_l = 0;
            end else begin
              if (wr && a == TOP - 1) ef_l = 1;
              if (rd && a == TOP)     ef_r = 0;
            end
            check(tag_of(p, 3'(c), a), ~ef_l, ~ef_r);
          end

    // R9: hold over idle cycles with both flags set
    do_reset();
    step(WR, TOP, WR, TOP - 1);
    repeat (5) @(negedge clk);
    check("R9", 1'b0, 1'b0);

    // R8: set and clear of the right flag together, from clear and from set
    do_reset();
    step(WR, TOP, RD, TOP);
    check("R8", 1'b1, 1'b0);
    step(WR, TOP, RD, TOP);
    check("R8", 1'b1, 1'b0);
    // R8: same for the left flag
    step(RD, TOP - 1, WR, TOP - 1);
    check("R8", 1'b0, 1'b0);
    // R3 and R5 together: both ports take their mail in one cycle
    step(RD, TOP - 1, RD, TOP);
    check("R3", 1'b1, 1'b1);
    // R1: reset while both flags are set
    step(WR, TOP, WR, TOP - 1);
    check("R2", 1'b0, 1'b0);
    do_reset();
    check("R1", 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule